// File: doc/BRIEF.md
# Relative-Jump Program Counter with Return Stack

This block holds the instruction address of a small processor whose program memory is sized by a parameter, anywhere from 256 to 8192 words in powers of two. Each cycle, a controller raises at most one command strobe. The block then steps the address, takes a relative skip, takes a skip that depends on a flag, or enters or leaves a subroutine or interrupt. The relative distance always comes from the low bits of the instruction word, so jump targets are never absolute.

An eight-entry return stack of 13-bit addresses is shared by three users: subroutine calls, table lookups and interrupt entry. One pop command serves all three. The block reports the stack fill level and full/empty status. It also raises a sticky error flag when a push meets a full stack or a pop meets an empty one. Program memory and flag generation sit outside the block.

Top module: `pc_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC, the stack level and the error flag are all cleared, so on the next cycle `pc_o`=0, `sp_o`=0, `err_o`=0 and `empty_o`=1.
- R2: `cmd_i` is one-hot or zero, with bit positions increment=0, jump=1, jump-if-zero=2, jump-if-carry=3, call=4, return=5, table-jump=6, interrupt=7. Increment sets PC to (PC+1) mod ROM_DEPTH. An all-zero `cmd_i` holds the PC.
- R3: Jump sets PC to (PC + off) mod ROM_DEPTH, where off is `ifield_i[12:0]` read as a 13-bit two's complement number. The PC never reaches ROM_DEPTH or above.
- R4: Jump-if-zero takes the relative jump of R3 only when `z_i`=1. Jump-if-carry does the same only when `c_i`=1. In all other cases the PC increments.
- R5: Call pushes (PC+1) mod ROM_DEPTH and takes the relative jump of R3.
- R6: Return loads the PC with the top stack entry and removes that entry.
- R7: Table-jump pushes (PC+1) mod ROM_DEPTH. It then sets the PC to (PC + 1 + idx) mod ROM_DEPTH, where idx is the unsigned field `ifield_i[11:4]`.
- R8: Interrupt pushes the current PC unchanged and loads the PC with the parameter ISR_ADDR.
- R9: The stack is last-in-first-out and holds STK_DEPTH entries. `sp_o` gives the entry count, `full_o` is 1 when the count equals STK_DEPTH, and `empty_o` is 1 when the count is zero.
- R10: A push onto a full stack leaves the entries and `sp_o` unchanged and sets `err_o`. The PC still moves to that command's target.
- R11: A return with an empty stack leaves `sp_o` at zero, sets `err_o`, and increments the PC.
- R12: Once set, `err_o` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 8 | One-hot command strobes |
| ifield_i | input | 13 | Low 13 bits of the instruction word (offset / table index) |
| z_i | input | 1 | Zero flag |
| c_i | input | 1 | Carry flag |
| pc_o | output | 13 | Program counter |
| sp_o | output | $clog2(STK_DEPTH+1) | Stack entry count |
| full_o | output | 1 | Stack full |
| empty_o | output | 1 | Stack empty |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench builds the block with ROM_DEPTH=256, STK_DEPTH=8 and ISR_ADDR=12. With a 256-word memory, a few hundred increments are enough to wrap the PC, and a negative 13-bit offset from a low address lands in the masked upper range. The non-default vector separates the interrupt target from ordinary step results. Eight stack entries let nested calls reach both the overflow and the underflow boundary in a short run.

// File: rtl/pcs_pkg.sv
// Shared constants for the program-counter sequencer.
// Assumes a 13-bit address space and a 13-bit relative offset field.
package pcs_pkg;
    localparam int PC_W   = 13;  // address and stack entry width
    localparam int CMD_W  = 8;   // number of command strobes
    localparam int GEN_LO = 4;   // table index field, low bit
    localparam int GEN_W  = 8;   // table index field width

    // command strobe bit positions
    localparam int C_INC  = 0;
    localparam int C_JMP  = 1;
    localparam int C_JZ   = 2;
    localparam int C_JC   = 3;
    localparam int C_CALL = 4;
    localparam int C_RET  = 5;
    localparam int C_TBL  = 6;
    localparam int C_IRQ  = 7;
endpackage

// File: rtl/pcs_stack.sv
// Return-address LIFO with an entry counter and a sticky misuse flag.
// Assumes push and pop are never requested in the same cycle.
module pcs_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 top,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty,
    output logic                         err
);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [LVL_W-1:0] lvl_m1;

    assign full   = (level == FULL_LVL);
    assign empty  = (level == '0);
    assign lvl_m1 = level - 1'b1;
    assign top    = mem[lvl_m1[IDX_W-1:0]];

    // entry count and sticky misuse flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            err   <= 1'b0;
        end else if (push) begin
            if (full) err   <= 1'b1;
            else      level <= level + 1'b1;
        end else if (pop) begin
            if (empty) err   <= 1'b1;
            else       level <= lvl_m1;
        end
    end

    // entry storage, written only on an accepted push
    always_ff @(posedge clk) begin
        if (push && !full) mem[level[IDX_W-1:0]] <= din;
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (level == FULL_LVL && err));
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (level == '0 && err));
    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);
    p_no_dual_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/pcs_next.sv
// Next-address selector: turns one command strobe into the next PC value
// and the stack request. Pure combinational logic.
// Assumes ROM_DEPTH is a power of two no larger than 2**PC_W.
module pcs_next
    import pcs_pkg::*;
#(
    parameter int ROM_DEPTH = 8192,
    parameter int ISR_ADDR  = 1
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  ifield,
    input  logic             z,
    input  logic             c,
    input  logic [PC_W-1:0]  stk_top,
    input  logic             stk_empty,
    output logic [PC_W-1:0]  pc_nxt,
    output logic             push,
    output logic             pop,
    output logic [PC_W-1:0]  push_data
);
    localparam logic [PC_W-1:0] MASK = PC_W'(ROM_DEPTH - 1);
    localparam logic [PC_W-1:0] VEC  = PC_W'(ISR_ADDR) & MASK;

    logic [PC_W-1:0] inc, rel, tbl;
    logic [GEN_W-1:0] idx;

    assign idx = ifield[GEN_LO +: GEN_W];
    assign inc = (pc + 1'b1) & MASK;
    assign rel = (pc + ifield) & MASK;   // 13-bit add is two's complement
    assign tbl = (inc + {{(PC_W-GEN_W){1'b0}}, idx}) & MASK;

    // choose target and stack action for the active strobe
    always_comb begin
        pc_nxt    = pc;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = inc;
        unique case (1'b1)
            cmd[C_INC]:  pc_nxt = inc;
            cmd[C_JMP]:  pc_nxt = rel;
            cmd[C_JZ]:   pc_nxt = z ? rel : inc;
            cmd[C_JC]:   pc_nxt = c ? rel : inc;
            cmd[C_CALL]: begin push = 1'b1; pc_nxt = rel; end
            cmd[C_TBL]:  begin push = 1'b1; pc_nxt = tbl; end
            cmd[C_RET]:  begin pop = 1'b1; pc_nxt = stk_empty ? inc : stk_top; end
            cmd[C_IRQ]:  begin push = 1'b1; push_data = pc; pc_nxt = VEC; end
            default:     pc_nxt = pc;
        endcase
    end
endmodule

// File: rtl/pc_seq.sv
// Program-counter sequencer: PC register, next-address selector and
// return stack. Assumes the controller raises at most one strobe per cycle.
module pc_seq
    import pcs_pkg::*;
#(
    parameter int ROM_DEPTH = 8192,
    parameter int STK_DEPTH = 8,
    parameter int ISR_ADDR  = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [7:0]                       cmd_i,
    input  logic [12:0]                      ifield_i,
    input  logic                             z_i,
    input  logic                             c_i,
    output logic [12:0]                      pc_o,
    output logic [$clog2(STK_DEPTH+1)-1:0]   sp_o,
    output logic                             full_o,
    output logic                             empty_o,
    output logic                             err_o
);
    localparam logic [PC_W-1:0] VEC = PC_W'(ISR_ADDR) & PC_W'(ROM_DEPTH - 1);

    logic [PC_W-1:0] pc_q, pc_d, push_data, stk_top;
    logic            push, pop;

    pcs_next #(.ROM_DEPTH(ROM_DEPTH), .ISR_ADDR(ISR_ADDR)) u_next (
        .cmd       (cmd_i),
        .pc        (pc_q),
        .ifield    (ifield_i),
        .z         (z_i),
        .c         (c_i),
        .stk_top   (stk_top),
        .stk_empty (empty_o),
        .pc_nxt    (pc_d),
        .push      (push),
        .pop       (pop),
        .push_data (push_data)
    );

    pcs_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (push_data),
        .top   (stk_top),
        .level (sp_o),
        .full  (full_o),
        .empty (empty_o),
        .err   (err_o)
    );

    // program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && sp_o == '0 && !err_o));
    p_cmd_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_i));
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == '0) |=> $stable(pc_o));
    p_pc_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pc_o) < ROM_DEPTH);
    p_ret_loads_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i[C_RET] && !empty_o) |=> (pc_o == $past(stk_top)));
    p_irq_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i[C_IRQ] |=> (pc_o == VEC));
endmodule

// File: tb/test_pc_seq.sv
// Bench for pc_seq: behavioural reference (integer PC, queue stack),
// compared after every clock.
module test_pc_seq;
    localparam int D   = 256;
    localparam int SD  = 8;
    localparam int ISR = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cmd_i = '0;
    logic [12:0] ifield_i = '0;
    logic        z_i = 1'b0, c_i = 1'b0;
    logic [12:0] pc_o;
    logic [3:0]  sp_o;
    logic        full_o, empty_o, err_o;

    int total = 0, bad = 0;
    int m_pc = 0;
    int m_stk[$];
    bit m_err = 0;
    bit done = 0;

    pc_seq #(.ROM_DEPTH(D), .STK_DEPTH(SD), .ISR_ADDR(ISR)) i_pc_seq (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ifield_i(ifield_i),
        .z_i(z_i), .c_i(c_i), .pc_o(pc_o), .sp_o(sp_o),
        .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
    );

    always #10 clk = ~clk;  // 50 MHz

    function automatic int wrapd(int v);
        return ((v % D) + D) % D;
    endfunction

    function automatic void m_push(int v);
        if (m_stk.size() == SD) m_err = 1;
        else m_stk.push_back(v);
    endfunction

    // compare every output with the reference
    task automatic check(string tag);
        total++;
        if (pc_o !== 13'(m_pc) || sp_o !== 4'(m_stk.size()) || err_o !== m_err ||
            full_o !== (m_stk.size() == SD) || empty_o !== (m_stk.size() == 0)) begin
            bad++;
            $display("FAIL %s: pc=%0d sp=%0d err=%0b full=%0b empty=%0b expected pc=%0d sp=%0d err=%0b",
                     tag, pc_o, sp_o, err_o, full_o, empty_o, m_pc, m_stk.size(), m_err);
        end
    endtask

    // apply one command at a falling edge, update the model, check one cycle later
    task automatic step(input logic [7:0] c, input logic [12:0] f,
                        input logic zf, input logic cf, input string tag);
        int inc, off, rel;
        cmd_i = c; ifield_i = f; z_i = zf; c_i = cf;
        inc = wrapd(m_pc + 1);
        off = f[12] ? int'(f) - 8192 : int'(f);
        rel = wrapd(m_pc + off);
        case (c)
            8'h01: m_pc = inc;
            8'h02: m_pc = rel;
            8'h04: m_pc = zf ? rel : inc;
            8'h08: m_pc = cf ? rel : inc;
            8'h10: begin m_push(inc); m_pc = rel; end
            8'h20: begin
                if (m_stk.size() == 0) begin m_err = 1; m_pc = inc; end
                else m_pc = m_stk.pop_back();
            end
            8'h40: begin m_push(inc); m_pc = wrapd(inc + int'(f[11:4])); end
            8'h80: begin m_push(m_pc); m_pc = ISR; end
            default: ;
        endcase
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_i = '0;
        @(negedge clk);
        @(negedge clk);
        m_pc = 0; m_stk.delete(); m_err = 0;
        check("R1 reset");
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        step(8'h00, 13'd0, 0, 0, "R2 idle hold");
        for (int i = 0; i < 260; i++) step(8'h01, 13'd0, 0, 0, "R2 increment/wrap");
        step(8'h00, 13'd0, 0, 0, "R2 idle hold");
        step(8'h02, 13'd5, 0, 0, "R3 jump forward");
        step(8'h02, 13'h1FEC, 0, 0, "R3 jump back past zero");
        step(8'h02, 13'h0FF0, 0, 0, "R3 large offset masked");
        step(8'h04, 13'd3, 0, 1, "R4 jz not taken");
        step(8'h04, 13'd3, 1, 0, "R4 jz taken");
        step(8'h08, 13'd3, 1, 0, "R4 jc not taken");
        step(8'h08, 13'h1FFE, 0, 1, "R4 jc taken back");
        for (int i = 0; i < SD; i++) step(8'h10, 13'd10, 0, 0, "R5 R9 nested call");
        step(8'h10, 13'd7, 0, 0, "R10 call on full stack");
        for (int i = 0; i < SD; i++) step(8'h20, 13'd0, 0, 0, "R6 R9 return");
        step(8'h20, 13'd0, 0, 0, "R11 return on empty stack");
        step(8'h01, 13'd0, 0, 0, "R12 error stays");
        step(8'h40, 13'h0030, 0, 0, "R7 table jump");
        step(8'h20, 13'd0, 0, 0, "R6 return from table");
        step(8'h80, 13'd0, 0, 0, "R8 interrupt entry");
        step(8'h01, 13'd0, 0, 0, "R2 step in service routine");
        step(8'h20, 13'd0, 0, 0, "R6 return from interrupt");
        step(8'h00, 13'd0, 0, 0, "R12 error still set");
        do_reset();
        step(8'h80, 13'd0, 0, 0, "R8 interrupt after reset");
        for (int i = 0; i < SD; i++) step(8'h80, 13'd0, 0, 0, "R9 R10 interrupt fill");
        for (int i = 0; i < 3; i++) step(8'h20, 13'd0, 0, 0, "R6 unwind");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule